// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Refresh

This block is a supervisory timer for a small microcontroller system. A counter advances on a base tick enable while the watchdog runs. When it rolls over from all ones it issues a reset request. Software keeps the system alive by refreshing the counter before that happens. A refresh loads the upper part of the counter from a software-writable reload register and clears the lower part.

A refresh only takes effect after two trigger writes arrive back to back on the register bus. A stray single write therefore cannot keep a runaway program alive. One bit of the reload register inserts an extra divide-by-16 stage ahead of the counter, which extends the timeout range sixteen-fold. The timer is started by a dedicated start input. Once running it cannot be stopped except by system reset, and its running state can be read back over the bus.

The counter is split into a low part of `LO_W` bits and a high part of `HI_W` bits. The reload value is `HI_W-1` bits wide and fills the high part below its most significant bit, which is always loaded as 0. The defaults give a 16-bit counter with a 7-bit reload value.

Top module: `wdt_timer`

## Requirements
- R1: After reset the counter is 0, the reload register reads 0, the running flag and the arm flag are 0, and `rst_req` is low.
- R2: Address 0 is the reload register. It can be written and read at any time, running or not. Bit 7 is the prescaler select, bits `HI_W-2`..0 hold the reload value, and all other bits read as 0.
- R3: A one-cycle pulse on `wd_start` sets the running flag, which reads back in bit 7 of address 1 and drives `running`. The counter does not move while the flag is 0, even with `tick` high.
- R4: Once set, the running flag stays set through any bus write and any further start pulse, until reset.
- R5: A write to address 1 with bit 0 set arms the trigger, and bit 0 of address 1 reads the arm flag. If the very next bus write goes to address 1 with bit 1 set, a refresh occurs on that write's clock edge. The refresh loads the high part of the counter with {0, reload value}, clears the low part, and clears the prescaler count.
- R6: A write with bit 1 set to address 1 while not armed causes no refresh, and an arming write on its own causes no refresh.
- R7: Any bus write to another address between the arming write and the firing write cancels the arm, and no refresh follows.
- R8: With the prescaler select at 0, the counter advances by one on every cycle in which `tick` is high while running. The reset request therefore follows a refresh by exactly 2^(LO_W+HI_W) − reload·2^LO_W ticks.
- R9: With the prescaler select at 1, the counter advances once every 16 ticks, which makes the timeout after a refresh 16 times longer than in R8.
- R10: When the counter rolls over from all ones, `rst_req` is high for exactly one cycle. The counter reloads as in R5 and keeps counting, so the next request follows after the same period.
- R11: Address 2 reads the low part of the counter and address 3 reads the high part, both zero-extended. Writes to these addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tick | input | 1 | Base count enable |
| wd_start | input | 1 | Start pulse, sets the running flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| running | output | 1 | Running flag |
| rst_req | output | 1 | One-cycle reset request on counter rollover |

## Verification
The bench builds the block with `LO_W = 4` and `HI_W = 4`, which gives an 8-bit counter and a 3-bit reload value. With these values a full timeout is a few hundred ticks without the prescaler and a few thousand with it. Both periods, and a second period after an automatic reload, are measured cycle by cycle. The trigger tests hold `tick` low, so any unwanted refresh shows up as a changed counter readback.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ADR_RELOAD = 2'd0,
    ADR_CTRL   = 2'd1,
    ADR_CNT_LO = 2'd2,
    ADR_CNT_HI = 2'd3
  } wdt_addr_e;

  localparam int BIT_ARM    = 0;
  localparam int BIT_FIRE   = 1;
  localparam int BIT_RUN    = 7;
  localparam int BIT_PRESEL = 7;

  // ticks from a refresh to the reset request
  function automatic int timeout_ticks(input int rel, input int lo_w,
                                       input int hi_w, input bit presel,
                                       input int div);
    int span;
    span = (1 << (lo_w + hi_w)) - rel * (1 << lo_w);
    return presel ? span * div : span;
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  input  logic sel,
  output logic step
);
  generate
    if (DIV > 1) begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      logic          at_end;
      assign at_end = (pre_q == PW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || clear || !sel) pre_q <= '0;
        else if (enable)             pre_q <= at_end ? '0 : pre_q + 1'b1;
      end
      assign step = enable && (!sel || at_end);
    end else begin : g_nodiv
      assign step = enable;
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh,
  input  logic             step,
  input  logic [HI_W-2:0]  reload_val,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             rst_req
);
  function automatic logic [CNT_W-1:0] load_word(input logic [HI_W-2:0] v);
    logic [CNT_W-1:0] w;
    w = '0;
    w[CNT_W-2:LO_W] = v;
    return w;
  endfunction

  logic [CNT_W-1:0] count_q;
  logic             req_q;

  assign overflow = step && !refresh && (&count_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= overflow;
      if (refresh || overflow) count_q <= load_word(reload_val);
      else if (step)           count_q <= count_q + 1'b1;
    end
  end

  assign count   = count_q;
  assign rst_req = req_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              running,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              presel,
  output logic [HI_W-2:0]   reload_val,
  output logic              armed,
  output logic              refresh
);
  logic            presel_q;
  logic [HI_W-2:0] reload_q;
  logic            armed_q;
  logic            wr_ctrl;

  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign refresh = wr_ctrl && armed_q && bus_wdata[BIT_FIRE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presel_q <= 1'b0;
      reload_q <= '0;
      armed_q  <= 1'b0;
    end else if (bus_wr) begin
      armed_q <= wr_ctrl && bus_wdata[BIT_ARM];
      if (bus_addr == ADR_RELOAD) begin
        presel_q <= bus_wdata[BIT_PRESEL];
        reload_q <= bus_wdata[HI_W-2:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_RELOAD: begin
        bus_rdata[HI_W-2:0]  = reload_q;
        bus_rdata[BIT_PRESEL] = presel_q;
      end
      ADR_CTRL: begin
        bus_rdata[BIT_ARM] = armed_q;
        bus_rdata[BIT_RUN] = running;
      end
      ADR_CNT_LO: bus_rdata = DATA_W'(count[LO_W-1:0]);
      default:    bus_rdata = DATA_W'(count[CNT_W-1:LO_W]);
    endcase
  end

  assign presel     = presel_q;
  assign reload_val = reload_q;
  assign armed      = armed_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  parameter int DIV  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wd_start,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        running,
  output logic        rst_req
);
  localparam int CNT_W = LO_W + HI_W;

  logic             run_q;
  logic             presel;
  logic [HI_W-2:0]  reload_val;
  logic             armed;
  logic             refresh_pulse;
  logic             count_step;
  logic             overflow;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_q | wd_start;
  end
  assign running = run_q;

  wdt_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .running(run_q), .count(count),
    .bus_rdata(bus_rdata), .presel(presel), .reload_val(reload_val),
    .armed(armed), .refresh(refresh_pulse)
  );

  wdt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(refresh_pulse),
    .enable(run_q && tick), .sel(presel), .step(count_step)
  );

  wdt_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .refresh(refresh_pulse), .step(count_step),
    .reload_val(reload_val), .count(count), .overflow(overflow),
    .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refresh_pulse,
  input logic             armed,
  input logic             count_step,
  input logic             overflow,
  input logic             running,
  input logic             rst_req,
  input logic [HI_W-2:0]  reload_val,
  input logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] loaded(input logic [HI_W-2:0] v);
    logic [CNT_W-1:0] w;
    w = '0;
    w[CNT_W-2:LO_W] = v;
    return w;
  endfunction

  assert_refresh_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |=> count == loaded($past(reload_val)));

  assert_fire_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |-> armed);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !refresh_pulse) |=> $stable(count));

  assert_run_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  assert_step_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_step && !refresh_pulse && !overflow) |=> count == $past(count) + 1'b1);

  assert_wrap_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> rst_req && count == loaded($past(reload_val)));

  assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
endmodule

bind wdt_timer wdt_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_pulse(refresh_pulse), .armed(armed),
  .count_step(count_step), .overflow(overflow), .running(running),
  .rst_req(rst_req), .reload_val(reload_val), .count(count)
);

// File: tb/tb_wdt_timer.sv
`timescale 1ns/1ps
module tb_wdt_timer;
  import wdt_pkg::*;
  localparam int LO_W = 4;
  localparam int HI_W = 4;
  localparam int DIV  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wd_start = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       running, rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_timer #(.LO_W(LO_W), .HI_W(HI_W), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wd_start(wd_start),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .running(running), .rst_req(rst_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic refresh_seq();
    wr(ADR_CTRL, 8'h01);
    wr(ADR_CTRL, 8'h02);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rst_req && n < 20000);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(ADR_CNT_LO, d); chk("R1 cnt lo", d, 0);
    rd(ADR_CNT_HI, d); chk("R1 cnt hi", d, 0);
    rd(ADR_RELOAD, d); chk("R1 reload", d, 0);
    rd(ADR_CTRL, d);   chk("R1 ctrl", d, 0);
    chk("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_reload_rw();
    logic [7:0] d;
    wr(ADR_RELOAD, 8'h85); rd(ADR_RELOAD, d); chk("R2 readback", d, 8'h85);
    wr(ADR_RELOAD, 8'hFF); rd(ADR_RELOAD, d); chk("R2 mask", d, 8'h87);
  endtask

  task automatic t_idle_then_start();
    logic [7:0] d;
    tick = 1'b1;
    repeat (20) @(negedge clk);
    rd(ADR_CNT_LO, d); chk("R3 idle lo", d, 0);
    tick = 1'b0;
    @(negedge clk); wd_start = 1'b1;
    @(negedge clk); wd_start = 1'b0;
    chk("R3 running", running, 1);
    rd(ADR_CTRL, d); chk("R3 status bit", d[7], 1);
  endtask

  task automatic t_triggers();
    logic [7:0] d;
    wr(ADR_RELOAD, 8'h05);
    wr(ADR_CTRL, 8'h01);
    rd(ADR_CTRL, d);   chk("R5 armed", d[0], 1);
    rd(ADR_CNT_HI, d); chk("R6 arm alone", d, 0);
    wr(ADR_CNT_LO, 8'h55);
    rd(ADR_CNT_LO, d); chk("R11 ro write", d, 0);
    rd(ADR_CTRL, d);   chk("R7 cancelled", d[0], 0);
    wr(ADR_CTRL, 8'h02);
    rd(ADR_CNT_HI, d); chk("R7 no refresh", d, 0);
    wr(ADR_CTRL, 8'h02);
    rd(ADR_CNT_HI, d); chk("R6 fire unarmed", d, 0);
    refresh_seq();
    rd(ADR_CNT_HI, d); chk("R5 hi loaded", d, 5);
    rd(ADR_CNT_LO, d); chk("R5 lo cleared", d, 0);
    rd(ADR_CNT_HI, d); chk("R11 hi read", d, 5);
  endtask

  task automatic t_period(input logic [7:0] rel, input string req);
    int n, t;
    t = timeout_ticks(int'(rel[2:0]), LO_W, HI_W, rel[7], DIV);
    wr(ADR_RELOAD, rel);
    refresh_seq();
    tick = 1'b1;
    bus_addr = ADR_CNT_HI;
    wait_req(n);
    chk({req, " period"}, n, t);
    #1 chk("R10 reloaded hi", bus_rdata, int'(rel[2:0]));
    @(negedge clk);
    chk("R10 one cycle", rst_req, 0);
    n = 1;
    while (!rst_req && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 second period", n, t);
    tick = 1'b0;
  endtask

  task automatic t_no_stop();
    logic [7:0] d;
    wr(ADR_CTRL, 8'h00);
    wr(ADR_RELOAD, 8'h00);
    @(negedge clk); wd_start = 1'b1;
    @(negedge clk); wd_start = 1'b0;
    rd(ADR_CTRL, d); chk("R4 sticky", d[7], 1);
    chk("R4 port", running, 1);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reload_rw();
    t_idle_then_start();
    t_triggers();
    t_period(8'h05, "R8");
    t_period(8'h83, "R9");
    t_no_stop();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule